// File: doc/BRIEF.md
# Exception Entry Sequencer

This controller moves a processor from ordinary execution into an exception handler. Several sources can hold exception requests at the same time. Each request carries a priority and an 8-bit vector number. When the sequencer is idle, it grants the winning request. It then runs a fixed series of steps, one after the other:

1. It records the status word and switches the core to supervisor mode with tracing off.
2. It pushes the interrupted program counter onto the supervisor stack.
3. It pushes the recorded status word onto the same stack.
4. It reads the handler address from the vector table.
5. It hands that address to the core as the new program counter, together with the updated supervisor stack pointer.

An internal trace source raises its own request after every retired instruction while the incoming status has its trace bit set. The core supplies the current program counter, status word and supervisor stack pointer. It applies the new status, the new program counter and the new stack pointer when the matching one-cycle write strobes pulse. Memory traffic goes through a write port and a read port. Both ports use a request/acknowledge handshake.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `busy`, `grant`, `sr_wr`, `pc_wr`, `ssp_wr`, `mem_wr_req` and `mem_rd_req` are all 0.
- R2: While idle, the sequencer accepts the pending request with the numerically largest priority. Ties go to the lowest source index, and the trace source has index NUM_REQ. One cycle after acceptance, `grant` is a one-hot pulse that lasts one cycle, with bit i marking source i.
- R3: In the cycle after acceptance, `sr_wr` pulses for one cycle. At that point `new_sr` equals the status captured at acceptance, with bit S_BIT (13) forced to 1 and bit T_BIT (15) forced to 0.
- R4: The first memory write goes to address ssp-4 and carries the captured program counter. The second goes to ssp-8 and carries the captured, unmodified status word, zero-extended to 32 bits. Here ssp is the stack pointer captured at acceptance.
- R5: After both pushes, a single read is issued at the vector number shifted left by two. The address is zero-extended to 32 bits.
- R6: `pc_wr` and `ssp_wr` pulse together for one cycle, in the cycle after the read is acknowledged. At that point `pc_val` is the read data and `ssp_val` is ssp-8. This is the last step, and the write and read requests are never high together.
- R7: Each memory request stays high, with its address and data unchanged, until the cycle in which its acknowledge is seen.
- R8: `busy` is high from the cycle after acceptance through the `pc_wr` cycle. Requests that appear while `busy` is high are not granted until the sequence has ended.
- R9: A pulse on `instr_done` while `cur_sr[15]` is 1 raises a trace request with vector TRACE_VEC (9) and priority TRACE_PRIO (1). That request stays pending until it is granted.
- R10: With no request pending, the sequencer stays idle and issues no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Per-source pending flag, held by the source until granted |
| req_prio | input | NUM_REQ*PRIO_W | Per-source priority, source i in bits [i*PRIO_W +: PRIO_W] |
| req_vec | input | NUM_REQ*VEC_W | Per-source vector number, source i in bits [i*VEC_W +: VEC_W] |
| instr_done | input | 1 | One pulse per retired instruction |
| cur_pc | input | AW | Program counter to be saved |
| cur_sr | input | SR_W | Current status word |
| cur_ssp | input | AW | Current supervisor stack pointer |
| grant | output | NUM_REQ+1 | One-hot acceptance pulse; top bit is the trace source |
| busy | output | 1 | Entry sequence in progress |
| sr_wr | output | 1 | Status update strobe |
| new_sr | output | SR_W | Status value in supervisor mode with trace off |
| mem_wr_req | output | 1 | Stack write request |
| mem_wr_addr | output | AW | Stack write address |
| mem_wr_data | output | AW | Stack write data |
| mem_wr_ack | input | 1 | Stack write acknowledge |
| mem_rd_req | output | 1 | Vector read request |
| mem_rd_addr | output | AW | Vector read address |
| mem_rd_ack | input | 1 | Vector read acknowledge, qualifies rd_data |
| mem_rd_data | input | AW | Handler address read from the table |
| pc_wr | output | 1 | Program counter load strobe |
| pc_val | output | AW | Handler address to load |
| ssp_wr | output | 1 | Stack pointer update strobe |
| ssp_val | output | AW | Stack pointer after both pushes |

## Verification
The embedded properties check several rules on every cycle:
- A pending access holds its request, address and data until it is acknowledged.
- The write and read ports are never active together.
- Any memory request implies `busy`.
- A program counter load always follows an acknowledged read.
- `grant` is at most one-hot.
- A status update differs from the captured status only in the supervisor and trace bits.
- A qualifying retirement always leaves a trace request pending.

Only the bench scenarios can show the rest:
- which source wins across a sweep of request masks and priority patterns, including ties;
- the exact push addresses and data;
- the vector address;
- that a request raised mid-sequence waits for the next sequence.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_MODE    = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_PUSH_SR = 3'd3,
    ST_FETCH   = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_t;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int NSRC   = 5,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 8
) (
  input  logic [NSRC-1:0]        valid,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [NSRC*VEC_W-1:0]  vec_flat,
  output logic                   any,
  output logic [NSRC-1:0]        onehot,
  output logic [VEC_W-1:0]       vec_sel
);
  logic [PRIO_W-1:0] prio_a [NSRC];
  logic [VEC_W-1:0]  vec_a  [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
    assign vec_a[g]  = vec_flat[g*VEC_W +: VEC_W];
  end

  // Strictly-greater compare keeps the lowest index on ties.
  always_comb begin
    logic [PRIO_W-1:0] best;
    any     = 1'b0;
    onehot  = '0;
    vec_sel = '0;
    best    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (valid[i] && (!any || prio_a[i] > best)) begin
        any     = 1'b1;
        best    = prio_a[i];
        onehot  = '0;
        onehot[i] = 1'b1;
        vec_sel = vec_a[i];
      end
    end
  end
endmodule

// File: rtl/exc_trace_flag.sv
module exc_trace_flag #(
  parameter int SR_W  = 16,
  parameter int T_BIT = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_done,
  input  logic [SR_W-1:0] cur_sr,
  input  logic            taken,
  output logic            pending
);
  logic set_now;
  logic pend_d;

  assign set_now = instr_done & cur_sr[T_BIT];

  always_comb begin
    pend_d = set_now | (pending & ~taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_d;
  end

  AST_TRACE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && cur_sr[T_BIT]) |=> pending); // R9
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_seq_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int VEC_W = 8,
  parameter int AW    = 32,
  parameter int SR_W  = 16,
  parameter int S_BIT = 13,
  parameter int T_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_any,
  input  logic [NSRC-1:0]  pick_onehot,
  input  logic [VEC_W-1:0] pick_vec,
  input  logic [AW-1:0]    cur_pc,
  input  logic [SR_W-1:0]  cur_sr,
  input  logic [AW-1:0]    cur_ssp,
  output logic [NSRC-1:0]  grant,
  output logic             busy,
  output logic             sr_wr,
  output logic [SR_W-1:0]  new_sr,
  output logic             mem_wr_req,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [AW-1:0]    mem_wr_data,
  input  logic             mem_wr_ack,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [AW-1:0]    mem_rd_data,
  output logic             pc_wr,
  output logic [AW-1:0]    pc_val,
  output logic             ssp_wr,
  output logic [AW-1:0]    ssp_val
);
  localparam logic [AW-1:0] SLOT   = AW'(4);
  localparam logic [AW-1:0] FRAME  = AW'(8);
  localparam int            PAD_SR = AW - SR_W;
  localparam int            PAD_VA = AW - VEC_W - 2;

  seq_state_t       state_q, state_d;
  logic             accept;
  logic             cap_en;
  logic             hdl_en;
  logic [NSRC-1:0]  grant_d;
  logic [SR_W-1:0]  sr_q;
  logic [AW-1:0]    pc_q;
  logic [AW-1:0]    ssp_q;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    hdl_q;

  assign accept = (state_q == ST_IDLE) && pick_any;
  assign cap_en = accept;
  assign hdl_en = (state_q == ST_FETCH) && mem_rd_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (pick_any)   state_d = ST_MODE;
      ST_MODE:                    state_d = ST_PUSH_PC;
      ST_PUSH_PC: if (mem_wr_ack) state_d = ST_PUSH_SR;
      ST_PUSH_SR: if (mem_wr_ack) state_d = ST_FETCH;
      ST_FETCH:   if (mem_rd_ack) state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
    grant_d = accept ? pick_onehot : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant   <= '0;
    end else begin
      state_q <= state_d;
      grant   <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      pc_q  <= '0;
      ssp_q <= '0;
      vec_q <= '0;
    end else if (cap_en) begin
      sr_q  <= cur_sr;
      pc_q  <= cur_pc;
      ssp_q <= cur_ssp;
      vec_q <= pick_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdl_q <= '0;
    else if (hdl_en) hdl_q <= mem_rd_data;
  end

  always_comb begin
    new_sr        = sr_q;
    new_sr[S_BIT] = 1'b1;
    new_sr[T_BIT] = 1'b0;
  end

  assign busy        = (state_q != ST_IDLE);
  assign sr_wr       = (state_q == ST_MODE);
  assign mem_wr_req  = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR);
  assign mem_wr_addr = (state_q == ST_PUSH_SR) ? (ssp_q - FRAME) : (ssp_q - SLOT);
  assign mem_wr_data = (state_q == ST_PUSH_SR) ? {{PAD_SR{1'b0}}, sr_q} : pc_q;
  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_rd_addr = {{PAD_VA{1'b0}}, vec_q, 2'b00};
  assign pc_wr       = (state_q == ST_DONE);
  assign pc_val      = hdl_q;
  assign ssp_wr      = (state_q == ST_DONE);
  assign ssp_val     = ssp_q - FRAME;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !mem_wr_req && !mem_rd_req && !pc_wr); // R1
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_SR_ONLY_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((new_sr ^ $past(cur_sr)) & ~((SR_W'(1) << S_BIT) | (SR_W'(1) << T_BIT))) == '0); // R3
  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_req && mem_rd_req)); // R6
  AST_PC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> $past(mem_rd_req && mem_rd_ack)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> mem_rd_req && $stable(mem_rd_addr)); // R7
  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req || mem_rd_req || pc_wr || sr_wr) |-> busy); // R8
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int              NUM_REQ    = 4,
  parameter int              PRIO_W     = 3,
  parameter int              VEC_W      = 8,
  parameter int              AW         = 32,
  parameter int              SR_W       = 16,
  parameter int              S_BIT      = 13,
  parameter int              T_BIT      = 15,
  parameter logic [VEC_W-1:0]  TRACE_VEC  = 8'd9,
  parameter logic [PRIO_W-1:0] TRACE_PRIO = 3'd1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_valid,
  input  logic [NUM_REQ*PRIO_W-1:0] req_prio,
  input  logic [NUM_REQ*VEC_W-1:0]  req_vec,
  input  logic                      instr_done,
  input  logic [AW-1:0]             cur_pc,
  input  logic [SR_W-1:0]           cur_sr,
  input  logic [AW-1:0]             cur_ssp,
  output logic [NUM_REQ:0]          grant,
  output logic                      busy,
  output logic                      sr_wr,
  output logic [SR_W-1:0]           new_sr,
  output logic                      mem_wr_req,
  output logic [AW-1:0]             mem_wr_addr,
  output logic [AW-1:0]             mem_wr_data,
  input  logic                      mem_wr_ack,
  output logic                      mem_rd_req,
  output logic [AW-1:0]             mem_rd_addr,
  input  logic                      mem_rd_ack,
  input  logic [AW-1:0]             mem_rd_data,
  output logic                      pc_wr,
  output logic [AW-1:0]             pc_val,
  output logic                      ssp_wr,
  output logic [AW-1:0]             ssp_val
);
  localparam int NSRC = NUM_REQ + 1;

  logic                   trace_pend;
  logic [NSRC-1:0]        all_valid;
  logic [NSRC*PRIO_W-1:0] all_prio;
  logic [NSRC*VEC_W-1:0]  all_vec;
  logic                   pick_any;
  logic [NSRC-1:0]        pick_onehot;
  logic [VEC_W-1:0]       pick_vec;

  assign all_valid = {trace_pend, req_valid};
  assign all_prio  = {TRACE_PRIO, req_prio};
  assign all_vec   = {TRACE_VEC, req_vec};

  exc_trace_flag #(.SR_W(SR_W), .T_BIT(T_BIT)) u_trace (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .cur_sr     (cur_sr),
    .taken      (grant[NSRC-1]),
    .pending    (trace_pend)
  );

  exc_prio_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_pick (
    .valid     (all_valid),
    .prio_flat (all_prio),
    .vec_flat  (all_vec),
    .any       (pick_any),
    .onehot    (pick_onehot),
    .vec_sel   (pick_vec)
  );

  exc_entry_fsm #(
    .NSRC(NSRC), .VEC_W(VEC_W), .AW(AW), .SR_W(SR_W), .S_BIT(S_BIT), .T_BIT(T_BIT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_any    (pick_any),
    .pick_onehot (pick_onehot),
    .pick_vec    (pick_vec),
    .cur_pc      (cur_pc),
    .cur_sr      (cur_sr),
    .cur_ssp     (cur_ssp),
    .grant       (grant),
    .busy        (busy),
    .sr_wr       (sr_wr),
    .new_sr      (new_sr),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ack  (mem_wr_ack),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .pc_wr       (pc_wr),
    .pc_val      (pc_val),
    .ssp_wr      (ssp_wr),
    .ssp_val     (ssp_val)
  );
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int NUM_REQ = 4;
  localparam int PRIO_W  = 3;
  localparam int VEC_W   = 8;
  localparam int AW      = 32;
  localparam int SR_W    = 16;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [NUM_REQ-1:0]        req_valid;
  logic [NUM_REQ*PRIO_W-1:0] req_prio;
  logic [NUM_REQ*VEC_W-1:0]  req_vec;
  logic                      instr_done;
  logic [AW-1:0]             cur_pc;
  logic [SR_W-1:0]           cur_sr;
  logic [AW-1:0]             cur_ssp;
  logic [NUM_REQ:0]          grant;
  logic                      busy, sr_wr, mem_wr_req, mem_rd_req, pc_wr, ssp_wr;
  logic [SR_W-1:0]           new_sr;
  logic [AW-1:0]             mem_wr_addr, mem_wr_data, mem_rd_addr, pc_val, ssp_val;
  logic                      mem_wr_ack, mem_rd_ack;
  logic [AW-1:0]             mem_rd_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
    .req_vec(req_vec), .instr_done(instr_done), .cur_pc(cur_pc), .cur_sr(cur_sr),
    .cur_ssp(cur_ssp), .grant(grant), .busy(busy), .sr_wr(sr_wr), .new_sr(new_sr),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .pc_wr(pc_wr), .pc_val(pc_val),
    .ssp_wr(ssp_wr), .ssp_val(ssp_val)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Poll at falling edges until a signal selected by kind is high (0 busy, 1 wr, 2 rd).
  task automatic wait_for(input int kind, input string tag);
    for (int n = 0; n < 40; n++) begin
      if ((kind == 0 && busy) || (kind == 1 && mem_wr_req) || (kind == 2 && mem_rd_req)) return;
      @(negedge clk);
    end
    chk(1'b0, tag, 0, 1);
  endtask

  task automatic serve_write(input int dly, input logic [AW-1:0] ea, input logic [AW-1:0] ed, input string tag);
    wait_for(1, tag);
    chk(mem_wr_addr == ea, {tag, " addr"}, mem_wr_addr, ea);
    chk(mem_wr_data == ed, {tag, " data"}, mem_wr_data, ed);
    chk(!mem_rd_req, "R6 no read during push", mem_rd_req, 0);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(mem_wr_req && mem_wr_addr == ea && mem_wr_data == ed, "R7 write held", mem_wr_addr, ea);
    end
    mem_wr_ack = 1'b1;
    @(negedge clk);
    mem_wr_ack = 1'b0;
  endtask

  task automatic run_entry(input int exp_idx, input logic [7:0] exp_vec, input logic [SR_W-1:0] sr0,
                           input logic [AW-1:0] pc0, input logic [AW-1:0] ssp0,
                           input logic [AW-1:0] hdl, input int dly);
    logic [SR_W-1:0] exp_sr;
    logic [AW-1:0]   exp_ra;
    exp_sr = (sr0 | 16'h2000) & 16'h7fff;
    exp_ra = {22'd0, exp_vec, 2'b00};
    wait_for(0, "R8 busy after accept");
    chk(grant == (5'd1 << exp_idx), "R2 winner", grant, 5'd1 << exp_idx);
    chk(sr_wr == 1'b1, "R3 status strobe", sr_wr, 1);
    chk(new_sr == exp_sr, "R3 new status", new_sr, exp_sr);
    @(negedge clk);
    chk(grant == '0 && !sr_wr, "R2 grant single pulse", grant, 0);
    serve_write(dly, ssp0 - 32'd4, pc0, "R4 push pc");
    serve_write((dly + 1) % 3, ssp0 - 32'd8, {16'd0, sr0}, "R4 push sr");
    wait_for(2, "R5 read issued");
    chk(mem_rd_addr == exp_ra, "R5 vector addr", mem_rd_addr, exp_ra);
    chk(!pc_wr, "R6 pc not yet loaded", pc_wr, 0);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(mem_rd_req && mem_rd_addr == exp_ra, "R7 read held", mem_rd_addr, exp_ra);
    end
    mem_rd_data = hdl;
    mem_rd_ack  = 1'b1;
    @(negedge clk);
    mem_rd_ack  = 1'b0;
    mem_rd_data = '0;
    chk(pc_wr && ssp_wr, "R6 load strobes", {pc_wr, ssp_wr}, 2'b11);
    chk(pc_val == hdl, "R6 pc value", pc_val, hdl);
    chk(ssp_val == ssp0 - 32'd8, "R6 ssp value", ssp_val, ssp0 - 32'd8);
    chk(busy, "R8 busy through load", busy, 1);
    @(negedge clk);
    chk(!busy && !pc_wr, "R8 idle after load", busy, 0);
  endtask

  task automatic set_req(input int i, input bit v, input int p, input logic [7:0] vec);
    req_valid[i] = v;
    req_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(p);
    req_vec[i*VEC_W +: VEC_W] = vec;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = '0; req_prio = '0; req_vec = '0; instr_done = 1'b0;
    cur_pc = '0; cur_sr = '0; cur_ssp = '0; mem_wr_ack = 1'b0; mem_rd_ack = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy && grant == '0 && !sr_wr && !pc_wr && !ssp_wr && !mem_wr_req && !mem_rd_req,
        "R1 reset outputs", {busy, mem_wr_req, mem_rd_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_wr_req && !mem_rd_req, "R10 idle without requests", busy, 0);

    // R2 R3 R4 R5 R6 sweep: every nonempty mask under four priority patterns.
    for (int pat = 0; pat < 4; pat++) begin
      for (int mask = 1; mask < 16; mask++) begin
        int best_i;
        int best_p;
        logic [SR_W-1:0] sr0;
        best_i = -1; best_p = 0;
        for (int i = 0; i < NUM_REQ; i++) begin
          int p;
          p = (pat == 0) ? 3 : ((i * (pat + 1) + mask) % 8);
          set_req(i, mask[i], p, 8'(8'h40 + 16 * i + mask));
          if (mask[i] && (best_i < 0 || p > best_p)) begin
            best_i = i; best_p = p;
          end
        end
        sr0 = (pat == 3) ? 16'h8005 ^ 16'(mask) : 16'h0700 ^ 16'(mask);
        cur_sr  = sr0;
        cur_pc  = 32'h1000_0000 + 32'(pat * 256 + mask * 4);
        cur_ssp = 32'h0000_8000 - 32'(mask * 16);
        run_entry(best_i, 8'(8'h40 + 16 * best_i + mask), sr0, cur_pc, cur_ssp,
                  32'hA000_0000 + 32'(mask), (pat + mask) % 3);
        req_valid = '0;
        @(negedge clk);
      end
    end

    // R8: a higher-priority request raised mid-sequence waits for the next sequence.
    set_req(0, 1'b1, 2, 8'h21);
    cur_sr = 16'h0001; cur_pc = 32'h0000_2000; cur_ssp = 32'h0000_9000;
    wait_for(0, "R8 first accept");
    set_req(3, 1'b1, 7, 8'h33);
    run_entry(0, 8'h21, 16'h0001, 32'h0000_2000, 32'h0000_9000, 32'h0000_5000, 1);
    req_valid[0] = 1'b0;
    run_entry(3, 8'h33, 16'h0001, 32'h0000_2000, 32'h0000_9000, 32'h0000_6000, 0);
    req_valid = '0;
    @(negedge clk);

    // R9: trace request raised by a retirement with T set, then taken with its own vector.
    cur_sr = 16'h8000;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    run_entry(NUM_REQ, 8'd9, 16'h8000, 32'h0000_2000, 32'h0000_9000, 32'h0000_7000, 1);
    // R9: a retirement with T clear raises nothing.
    cur_sr = 16'h2000;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && grant == '0, "R9 no trace when T clear", busy, 0);
    // R2 tie with trace: external prio 1 at index 0 beats trace prio 1.
    cur_sr = 16'h8000;
    set_req(0, 1'b1, 1, 8'h11);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    run_entry(0, 8'h11, 16'h8000, 32'h0000_2000, 32'h0000_9000, 32'h0000_7100, 0);
    req_valid = '0;
    run_entry(NUM_REQ, 8'd9, 16'h8000, 32'h0000_2000, 32'h0000_9000, 32'h0000_7200, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_wr_req && !mem_rd_req, "R10 idle at end", busy, 0);
    finish_run();
  end
endmodule